// File: doc/BRIEF.md
# Transceiver Mode and Pad Direction Controller

This block sits between the configuration registers of a full/low-speed USB On-The-Go transceiver and its pad ring. From a handful of register fields, the speed and suspend pins and the level of the shared output-enable pin, it chooses the operating mode. The modes are USB, UART, transparent I2C and audio. It then works out which side drives every shared pad. Analog drivers, receivers and slew control are outside the block. It only hands them enables and selects.

Each clock, a decoder turns the configuration into a requested mode. A small state machine holds the active mode. It has the states ST_RESET, ST_USB, ST_UART, ST_I2C and ST_AUDIO. ST_RESET is left on the first clock after reset. From any mode state, the machine moves to whichever mode the decoder asks for (transitions USB↔UART↔I2C↔AUDIO in any pairing). A steering stage derives the pad enables from the requested mode. Everything leaves the block through registers, so every output reflects the inputs sampled at the previous rising clock edge, and reset parks every pad in input or high-impedance state.

Top module: `otgx_pad_ctrl`

## Requirements
- R1: While reset is low, and at the first sample after it is released before any clock edge, every enable and flag output is 0 and mode_code is 0.
- R2: Every output equals the function of the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: mode_code is 1 (UART) whenever cfg_uart_en=1, regardless of cfg_passthru. It is 2 (I2C) when only cfg_passthru=1. It is 3 (audio) when both are 0, pin_oe_hi=1 and cfg_ctl2 is all zeros. Otherwise it is 0 (USB).
- R4: In audio mode, all line, digital-pad and RCV enables are 0, and pulls_release=1 and vbus_block=1. Outside audio mode, both flags are 0.
- R5: full_speed is 1 only when cfg_speed=1 and pin_speed=1.
- R6: power_down is 1 when cfg_suspend=1 or pin_suspend=1.
- R7: In USB mode, usb_se0_enc equals cfg_dat_se0 (1 = data/SE0 encoding, 0 = separate D+/D- levels), and both line enables equal the inverse of pin_oe_hi. Outside USB mode, usb_se0_enc is 0.
- R8: In USB mode, dig_dp_oe and dig_dm_oe are 1 only when cfg_bidi=1 and pin_oe_hi=1.
- R9: rcv_oe is 1 only in USB mode with cfg_dat_se0=0 and pin_oe_hi=1.
- R10: In UART mode, bit 1 of cfg_uart_dir steers the D+ pair and bit 0 steers the D- pair. A 0 means line enable 1 and digital-pad enable 0. A 1 means the reverse.
- R11: In I2C mode, slave_mute=1. With pin_oe_hi=0, dp_open_drain, dp_pullup_en, line_dp_oe and line_dm_oe are all 1. With pin_oe_hi=1, all four are 0. Outside I2C mode, slave_mute, dp_open_drain and dp_pullup_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_speed | input | 1 | Speed register bit |
| cfg_suspend | input | 1 | Suspend register bit |
| cfg_dat_se0 | input | 1 | USB encoding select bit |
| cfg_passthru | input | 1 | Transparent I2C enable bit |
| cfg_uart_en | input | 1 | UART enable bit |
| cfg_bidi | input | 1 | Digital pad bidirectional enable |
| cfg_uart_dir | input | 2 | UART per-line direction bits |
| cfg_ctl2 | input | CTL2_W | Second control byte (pulls, VBUS controls) |
| pin_speed | input | 1 | Speed pin level |
| pin_suspend | input | 1 | Suspend pin level |
| pin_oe_hi | input | 1 | Level of the shared output-enable pin (1 = high) |
| mode_code | output | 2 | Active mode: 0 USB, 1 UART, 2 I2C, 3 audio |
| full_speed | output | 1 | Full-speed select |
| power_down | output | 1 | Power-down request |
| usb_se0_enc | output | 1 | USB encoding route select |
| dig_dp_oe | output | 1 | Drive the data/VP digital pad |
| dig_dm_oe | output | 1 | Drive the SE0/VM digital pad |
| rcv_oe | output | 1 | Drive the differential receiver output pad |
| line_dp_oe | output | 1 | Drive D+ |
| line_dm_oe | output | 1 | Drive D- |
| dp_open_drain | output | 1 | D+ driver in open-drain form |
| dp_pullup_en | output | 1 | D+ pull-up for I2C data |
| pulls_release | output | 1 | Release D+, D- and ID pull resistors |
| vbus_block | output | 1 | Inhibit any VBUS drive |
| slave_mute | output | 1 | Register slave ignores bus traffic |

## Verification
Two functions can fall in the same cycle when one input change both switches the mode and flips pad direction. The sharpest case is the output-enable pin. With cfg_ctl2 zero and no mode bit set, its rise enters audio mode and its fall drops back to USB with the lines driven. In I2C mode, the same edge swaps the open-drain and pull-up together. The bench forces these with back-to-back vectors that toggle only pin_oe_hi. Random vectors draw cfg_ctl2=0 often enough to hit the boundary repeatedly. Every field is compared, one cycle later, against a bench model of the mode and steering rules, so a stale mode with fresh enables is caught.

// File: rtl/otgx_pkg.sv
package otgx_pkg;

    typedef enum logic [1:0] {
        MODE_USB   = 2'd0,
        MODE_UART  = 2'd1,
        MODE_I2C   = 2'd2,
        MODE_AUDIO = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_USB   = 3'd1,
        ST_UART  = 3'd2,
        ST_I2C   = 3'd3,
        ST_AUDIO = 3'd4
    } state_e;

    typedef struct packed {
        logic usb_se0_enc;
        logic dig_dp_oe;
        logic dig_dm_oe;
        logic rcv_oe;
        logic line_dp_oe;
        logic line_dm_oe;
        logic dp_open_drain;
        logic dp_pullup_en;
        logic pulls_release;
        logic vbus_block;
        logic slave_mute;
    } pad_ctl_t;

    localparam int UART_DIR_W  = 2;
    localparam int DIR_DP_BIT  = 1;
    localparam int DIR_DM_BIT  = 0;

endpackage

// File: rtl/otgx_mode_decode.sv
module otgx_mode_decode
    import otgx_pkg::*;
#(
    parameter int CTL2_W = 8
) (
    input  logic              uart_en,
    input  logic              passthru,
    input  logic              oe_hi,
    input  logic [CTL2_W-1:0] ctl2,
    output mode_e             mode_req
);
    localparam logic [CTL2_W-1:0] CTL2_IDLE = '0;

    always_comb begin
        if (uart_en)
            mode_req = MODE_UART;
        else if (passthru)
            mode_req = MODE_I2C;
        else if (oe_hi && (ctl2 == CTL2_IDLE))
            mode_req = MODE_AUDIO;
        else
            mode_req = MODE_USB;
    end
endmodule

// File: rtl/otgx_mode_fsm.sv
module otgx_mode_fsm
    import otgx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_req,
    output mode_e mode_cur
);
    state_e state_q;
    state_e state_d;

    function automatic state_e to_state(input mode_e m);
        state_e s;
        unique case (m)
            MODE_USB:   s = ST_USB;
            MODE_UART:  s = ST_UART;
            MODE_I2C:   s = ST_I2C;
            MODE_AUDIO: s = ST_AUDIO;
            default:    s = ST_USB;
        endcase
        return s;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = to_state(mode_req);
            ST_USB:   state_d = to_state(mode_req);
            ST_UART:  state_d = to_state(mode_req);
            ST_I2C:   state_d = to_state(mode_req);
            ST_AUDIO: state_d = to_state(mode_req);
            default:  state_d = ST_RESET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_UART:  mode_cur = MODE_UART;
            ST_I2C:   mode_cur = MODE_I2C;
            ST_AUDIO: mode_cur = MODE_AUDIO;
            default:  mode_cur = MODE_USB;
        endcase
    end

    a_r1_leaves_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) |=> (state_q != ST_RESET));
endmodule

// File: rtl/otgx_pad_steer.sv
module otgx_pad_steer
    import otgx_pkg::*;
(
    input  mode_e                 mode_req,
    input  logic                  dat_se0,
    input  logic                  bidi,
    input  logic [UART_DIR_W-1:0] uart_dir,
    input  logic                  oe_hi,
    output pad_ctl_t              pads
);
    always_comb begin
        pads = '0;
        unique case (mode_req)
            MODE_USB: begin
                pads.usb_se0_enc = dat_se0;
                pads.line_dp_oe  = !oe_hi;
                pads.line_dm_oe  = !oe_hi;
                pads.dig_dp_oe   = bidi && oe_hi;
                pads.dig_dm_oe   = bidi && oe_hi;
                pads.rcv_oe      = !dat_se0 && oe_hi;
            end
            MODE_UART: begin
                pads.dig_dp_oe  = uart_dir[DIR_DP_BIT];
                pads.line_dp_oe = !uart_dir[DIR_DP_BIT];
                pads.dig_dm_oe  = uart_dir[DIR_DM_BIT];
                pads.line_dm_oe = !uart_dir[DIR_DM_BIT];
            end
            MODE_I2C: begin
                pads.slave_mute    = 1'b1;
                pads.dp_open_drain = !oe_hi;
                pads.dp_pullup_en  = !oe_hi;
                pads.line_dp_oe    = !oe_hi;
                pads.line_dm_oe    = !oe_hi;
            end
            MODE_AUDIO: begin
                pads.pulls_release = 1'b1;
                pads.vbus_block    = 1'b1;
            end
            default: pads = '0;
        endcase
    end
endmodule

// File: rtl/otgx_pad_ctrl.sv
module otgx_pad_ctrl
    import otgx_pkg::*;
#(
    parameter int CTL2_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_speed,
    input  logic              cfg_suspend,
    input  logic              cfg_dat_se0,
    input  logic              cfg_passthru,
    input  logic              cfg_uart_en,
    input  logic              cfg_bidi,
    input  logic [1:0]        cfg_uart_dir,
    input  logic [CTL2_W-1:0] cfg_ctl2,
    input  logic              pin_speed,
    input  logic              pin_suspend,
    input  logic              pin_oe_hi,
    output logic [1:0]        mode_code,
    output logic              full_speed,
    output logic              power_down,
    output logic              usb_se0_enc,
    output logic              dig_dp_oe,
    output logic              dig_dm_oe,
    output logic              rcv_oe,
    output logic              line_dp_oe,
    output logic              line_dm_oe,
    output logic              dp_open_drain,
    output logic              dp_pullup_en,
    output logic              pulls_release,
    output logic              vbus_block,
    output logic              slave_mute
);
    mode_e    mode_req;
    mode_e    mode_cur;
    pad_ctl_t pads_d;
    pad_ctl_t pads_q;
    logic     fs_q;
    logic     pd_q;
    logic     live_q;

    otgx_mode_decode #(.CTL2_W(CTL2_W)) u_dec (
        .uart_en  (cfg_uart_en),
        .passthru (cfg_passthru),
        .oe_hi    (pin_oe_hi),
        .ctl2     (cfg_ctl2),
        .mode_req (mode_req)
    );

    otgx_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .mode_cur (mode_cur)
    );

    otgx_pad_steer u_steer (
        .mode_req (mode_req),
        .dat_se0  (cfg_dat_se0),
        .bidi     (cfg_bidi),
        .uart_dir (cfg_uart_dir),
        .oe_hi    (pin_oe_hi),
        .pads     (pads_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pads_q <= '0;
            fs_q   <= 1'b0;
            pd_q   <= 1'b0;
            live_q <= 1'b0;
        end else begin
            pads_q <= pads_d;
            fs_q   <= cfg_speed && pin_speed;
            pd_q   <= cfg_suspend || pin_suspend;
            live_q <= 1'b1;
        end
    end

    assign mode_code     = mode_cur;
    assign full_speed    = fs_q;
    assign power_down    = pd_q;
    assign usb_se0_enc   = pads_q.usb_se0_enc;
    assign dig_dp_oe     = pads_q.dig_dp_oe;
    assign dig_dm_oe     = pads_q.dig_dm_oe;
    assign rcv_oe        = pads_q.rcv_oe;
    assign line_dp_oe    = pads_q.line_dp_oe;
    assign line_dm_oe    = pads_q.line_dm_oe;
    assign dp_open_drain = pads_q.dp_open_drain;
    assign dp_pullup_en  = pads_q.dp_pullup_en;
    assign pulls_release = pads_q.pulls_release;
    assign vbus_block    = pads_q.vbus_block;
    assign slave_mute    = pads_q.slave_mute;

    a_r1_first_cycle_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !live_q |-> (pads_q == '0) && (mode_code == 2'd0));

    a_r4_audio_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_AUDIO) |-> (!line_dp_oe && !line_dm_oe && !dig_dp_oe
            && !dig_dm_oe && !rcv_oe && vbus_block && pulls_release));

    a_r5_speed_and: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        full_speed == $past(cfg_speed && pin_speed));

    a_r6_power_or: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        power_down == $past(cfg_suspend || pin_suspend));

    a_r10_uart_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_UART) |-> ((line_dp_oe != dig_dp_oe) && (line_dm_oe != dig_dm_oe)));

    a_r11_i2c_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_I2C) |-> (slave_mute && !rcv_oe && !dig_dp_oe));

    a_r3_uart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_uart_en |=> (mode_code == MODE_UART));
endmodule

// File: tb/sim_otgx_pad_ctrl.sv
module sim_otgx_pad_ctrl;
    localparam int CTL2_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_speed = 0, cfg_suspend = 0, cfg_dat_se0 = 0, cfg_passthru = 0;
    logic cfg_uart_en = 0, cfg_bidi = 0;
    logic [1:0] cfg_uart_dir = '0;
    logic [CTL2_W-1:0] cfg_ctl2 = '0;
    logic pin_speed = 0, pin_suspend = 0, pin_oe_hi = 0;

    logic [1:0] mode_code;
    logic full_speed, power_down, usb_se0_enc, dig_dp_oe, dig_dm_oe, rcv_oe;
    logic line_dp_oe, line_dm_oe, dp_open_drain, dp_pullup_en;
    logic pulls_release, vbus_block, slave_mute;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected values
    logic [1:0] e_mode;
    logic e_fs, e_pd, e_enc, e_ddp, e_ddm, e_rcv, e_ldp, e_ldm, e_od, e_pu, e_rel, e_vb, e_mute;

    always #5 clk = ~clk;

    otgx_pad_ctrl #(.CTL2_W(CTL2_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_speed(cfg_speed), .cfg_suspend(cfg_suspend), .cfg_dat_se0(cfg_dat_se0),
        .cfg_passthru(cfg_passthru), .cfg_uart_en(cfg_uart_en), .cfg_bidi(cfg_bidi),
        .cfg_uart_dir(cfg_uart_dir), .cfg_ctl2(cfg_ctl2),
        .pin_speed(pin_speed), .pin_suspend(pin_suspend), .pin_oe_hi(pin_oe_hi),
        .mode_code(mode_code), .full_speed(full_speed), .power_down(power_down),
        .usb_se0_enc(usb_se0_enc), .dig_dp_oe(dig_dp_oe), .dig_dm_oe(dig_dm_oe),
        .rcv_oe(rcv_oe), .line_dp_oe(line_dp_oe), .line_dm_oe(line_dm_oe),
        .dp_open_drain(dp_open_drain), .dp_pullup_en(dp_pullup_en),
        .pulls_release(pulls_release), .vbus_block(vbus_block), .slave_mute(slave_mute)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Bench model of the requirements
    task automatic model();
        e_fs = cfg_speed & pin_speed;
        e_pd = cfg_suspend | pin_suspend;
        {e_enc, e_ddp, e_ddm, e_rcv, e_ldp, e_ldm, e_od, e_pu, e_rel, e_vb, e_mute} = '0;
        if (cfg_uart_en) e_mode = 2'd1;
        else if (cfg_passthru) e_mode = 2'd2;
        else if (pin_oe_hi && cfg_ctl2 == '0) e_mode = 2'd3;
        else e_mode = 2'd0;
        case (e_mode)
            2'd0: begin
                e_enc = cfg_dat_se0;
                e_ldp = !pin_oe_hi; e_ldm = !pin_oe_hi;
                e_ddp = cfg_bidi & pin_oe_hi; e_ddm = cfg_bidi & pin_oe_hi;
                e_rcv = !cfg_dat_se0 & pin_oe_hi;
            end
            2'd1: begin
                e_ddp = cfg_uart_dir[1]; e_ldp = !cfg_uart_dir[1];
                e_ddm = cfg_uart_dir[0]; e_ldm = !cfg_uart_dir[0];
            end
            2'd2: begin
                e_mute = 1'b1;
                e_od = !pin_oe_hi; e_pu = !pin_oe_hi;
                e_ldp = !pin_oe_hi; e_ldm = !pin_oe_hi;
            end
            default: begin
                e_rel = 1'b1; e_vb = 1'b1;
            end
        endcase
    endtask

    task automatic compare_all();
        chk("R3", "mode_code", mode_code, e_mode);
        chk("R5", "full_speed", full_speed, e_fs);
        chk("R6", "power_down", power_down, e_pd);
        chk("R7", "usb_se0_enc", usb_se0_enc, e_enc);
        chk("R8_R10", "dig_dp_oe", dig_dp_oe, e_ddp);
        chk("R8_R10", "dig_dm_oe", dig_dm_oe, e_ddm);
        chk("R9", "rcv_oe", rcv_oe, e_rcv);
        chk("R7_R11", "line_dp_oe", line_dp_oe, e_ldp);
        chk("R7_R11", "line_dm_oe", line_dm_oe, e_ldm);
        chk("R11", "dp_open_drain", dp_open_drain, e_od);
        chk("R11", "dp_pullup_en", dp_pullup_en, e_pu);
        chk("R4", "pulls_release", pulls_release, e_rel);
        chk("R4", "vbus_block", vbus_block, e_vb);
        chk("R11", "slave_mute", slave_mute, e_mute);
    endtask

    // Apply at a falling edge, check at the next falling edge (R2: one register stage)
    task automatic apply(input logic sp, input logic su, input logic ds, input logic pt,
                         input logic ue, input logic bi, input logic [1:0] dir,
                         input logic [CTL2_W-1:0] c2, input logic psp, input logic psu,
                         input logic oe);
        cfg_speed = sp; cfg_suspend = su; cfg_dat_se0 = ds; cfg_passthru = pt;
        cfg_uart_en = ue; cfg_bidi = bi; cfg_uart_dir = dir; cfg_ctl2 = c2;
        pin_speed = psp; pin_suspend = psu; pin_oe_hi = oe;
        model();
        @(negedge clk);
        compare_all();
    endtask

    task automatic check_idle(input string tag);
        chk("R1", {tag, " mode_code"}, mode_code, 0);
        chk("R1", {tag, " enables"},
            int'({full_speed, power_down, usb_se0_enc, dig_dp_oe, dig_dm_oe, rcv_oe,
                  line_dp_oe, line_dm_oe, dp_open_drain, dp_pullup_en,
                  pulls_release, vbus_block, slave_mute}), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: inputs busy while reset is held
        cfg_speed = 1; pin_speed = 1; cfg_suspend = 1; pin_oe_hi = 1; cfg_uart_en = 1;
        repeat (3) @(negedge clk);
        check_idle("in reset");
        rst_n = 1'b1;
        check_idle("after release");

        // R2/R7/R8: USB data/SE0 encoding, bidirectional, OE high then low
        apply(1,0,1,0,0,1,2'b00,8'h01,1,0,1);
        apply(1,0,1,0,0,1,2'b00,8'h01,1,0,0);
        // R9: VP_VM encoding, OE high, not bidirectional
        apply(0,0,0,0,0,0,2'b00,8'h10,1,0,1);
        // R3: both UART and transparent bits -> UART
        apply(0,0,0,1,1,0,2'b01,8'h00,0,0,1);
        // R10: every direction pair
        for (int d = 0; d < 4; d++) apply(0,0,0,0,1,1,2'(d),8'h00,0,0,0);
        // R3/R4: audio entry and its edge by OE toggle
        apply(1,1,0,0,0,1,2'b11,8'h00,1,1,1);
        apply(1,1,0,0,0,1,2'b11,8'h00,1,1,0);
        apply(1,1,0,0,0,1,2'b11,8'h00,1,1,1);
        // R3: OE high but control byte nonzero stays USB
        apply(0,0,0,0,0,1,2'b00,8'h80,0,0,1);
        // R11: I2C with OE low then high
        apply(0,0,0,1,0,0,2'b00,8'h00,0,0,0);
        apply(0,0,0,1,0,0,2'b00,8'h00,0,0,1);
        // R5/R6: speed and suspend combinations
        for (int k = 0; k < 4; k++)
            apply(k[0],k[1],0,0,0,0,2'b00,8'h01,k[1],k[0],0);

        // Random mix, control byte often zero to hit the audio boundary
        for (int n = 0; n < 400; n++) begin
            logic [CTL2_W-1:0] c2;
            c2 = ($urandom % 3 == 0) ? '0 : CTL2_W'($urandom);
            apply($urandom%2, $urandom%2, $urandom%2, ($urandom%3==0),
                  ($urandom%4==0), $urandom%2, 2'($urandom), c2,
                  $urandom%2, $urandom%2, $urandom%2);
        end

        // R1: reset again in mid-operation
        apply(1,0,0,1,0,0,2'b00,8'h00,1,0,0);
        rst_n = 1'b0;
        #1;
        check_idle("re-reset");
        @(negedge clk);
        rst_n = 1'b1;
        apply(1,0,0,0,1,0,2'b10,8'h00,1,0,1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule